// File: doc/BRIEF.md
# Memory Word Error Correction with Failure Logging

This block sits between a 16-bit processor data path and a memory array. On the write side it turns each data word into a check field that is stored next to the word. On the read side it takes the stored word and its check field, finds and repairs a single flipped bit, and flags any damage it cannot repair to the processor. A mode input picks one of two protections: a 6-bit Hamming code with overall parity (single-error-correct, double-error-detect) or one plain even parity bit.

Two diagnostic registers help software find faulty memory. One holds the most recent word that was repaired. The other holds the address of the first read that showed any error, together with a valid flag. Later errors never overwrite that address. Only a clear strobe from software re-arms it. A sticky status bit records that at least one repair has happened since the last clear.

All outputs are registered. A read presented on one clock edge yields its result, flags and log updates on the next edge.

Top module: `edac_guard`

## Requirements
- R1: With `secded_en`=1, a word read back together with the check field that `wr_check` produced for it is returned unchanged, with `rd_out_corrected`=0 and `rd_out_uncorr`=0. `wr_check` follows `wr_data` with one cycle of latency.
- R2: With `secded_en`=1, if exactly one of the 16 data bits is flipped, the original word is returned, `rd_out_corrected`=1 and `rd_out_uncorr`=0.
- R3: With `secded_en`=1, if exactly one of the 6 check bits is flipped, the data is returned unchanged and `rd_out_corrected`=1 and `rd_out_uncorr`=0.
- R4: With `secded_en`=1, any two flipped bits (data or check) give `rd_out_uncorr`=1 and `rd_out_corrected`=0. The two flags are never high together.
- R5: With `secded_en`=0, `wr_check` bit 0 is the XOR of the 16 data bits and bits 5:1 are 0. On a read, a mismatch between bit 0 and the XOR of the data gives `rd_out_uncorr`=1. The data is always passed through unmodified, `rd_out_corrected` stays 0, and check bits 5:1 are ignored.
- R6: `diag_data` is loaded with the repaired word on every read that raises `rd_out_corrected`. It keeps its value on all other cycles.
- R7: A read with either flag set while `fail_valid`=0 loads its `rd_addr` into `fail_addr` and sets `fail_valid`. While `fail_valid`=1, later errors leave `fail_addr` unchanged.
- R8: A `fail_clr` pulse clears `fail_valid` and `ce_sticky`. If an erroring read occurs in the same cycle as the clear, that read is captured as the new first failure and its status is set.
- R9: `ce_sticky` is set by any corrected read and stays set until `fail_clr`.
- R10: After reset, `rd_out_valid`, both flags, `ce_sticky`, `fail_valid`, `diag_data` and `fail_addr` are 0. `rd_out_valid` is a one-cycle pulse, one cycle after `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| secded_en | input | 1 | 1 = SEC-DED code, 0 = single parity bit |
| wr_data | input | 16 | Word being written to memory |
| wr_check | output | 6 | Check field to store with the word (registered) |
| rd_valid | input | 1 | A read word is present this cycle |
| rd_addr | input | 20 | Address of the read |
| rd_data | input | 16 | Data word from memory |
| rd_check | input | 6 | Check field from memory |
| fail_clr | input | 1 | Software strobe: re-arm failure log, clear sticky bit |
| rd_out_valid | output | 1 | Read result valid |
| rd_out_data | output | 16 | Read data after repair |
| rd_out_corrected | output | 1 | This read had a repaired single error |
| rd_out_uncorr | output | 1 | Error to processor: damage that cannot be repaired |
| ce_sticky | output | 1 | A repair has happened since the last clear |
| diag_data | output | 16 | Last repaired word |
| fail_valid | output | 1 | `fail_addr` holds a captured failure |
| fail_addr | output | 20 | Address of the first failing read |

## Verification
The assertions check on every cycle that the two error flags exclude each other and only appear with a valid result. They also check that parity mode never repairs or alters data, that a held failure address stays stable until a clear, that a clear with no new error drops the valid flag, and that the sticky bit holds. Whether the Hamming code really locates each flipped data or check bit can only be shown by the bench's scenarios. The same holds for the classification of double flips, the parity bit value, the content of the diagnostic word, and the capture order of failure addresses: each of these is driven with chosen words and chosen bit flips.

// File: rtl/edac_pkg.sv
package edac_pkg;

  // Number of Hamming check bits needed for dw data bits.
  function automatic int ham_bits(int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // Codeword position (1-based) of data bit idx: the idx-th position
  // that is not a power of two.
  function automatic int data_pos(int idx);
    int pos;
    int cnt;
    pos = 0;
    cnt = -1;
    while (cnt < idx) begin
      pos++;
      if ((pos & (pos - 1)) != 0) cnt++;
    end
    return pos;
  endfunction

endpackage

// File: rtl/edac_encoder.sv
module edac_encoder #(
  parameter int DATA_W = 16,
  localparam int HW = edac_pkg::ham_bits(DATA_W),
  localparam int CW = HW + 1
) (
  input  logic              secded,
  input  logic [DATA_W-1:0] data,
  output logic [CW-1:0]     check
);
  logic [HW-1:0] ham;

  always_comb begin
    int p;
    ham = '0;
    for (int i = 0; i < DATA_W; i++) begin
      p = edac_pkg::data_pos(i);
      for (int k = 0; k < HW; k++) begin
        if (((p >> k) & 1) == 1) ham[k] = ham[k] ^ data[i];
      end
    end
  end

  always_comb begin
    if (secded) check = {(^data) ^ (^ham), ham};
    else        check = {{HW{1'b0}}, ^data};
  end
endmodule

// File: rtl/edac_decoder.sv
module edac_decoder #(
  parameter int DATA_W = 16,
  localparam int HW = edac_pkg::ham_bits(DATA_W),
  localparam int CW = HW + 1
) (
  input  logic              secded,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CW-1:0]     check_in,
  output logic [DATA_W-1:0] data_out,
  output logic              corrected,
  output logic              uncorr
);
  logic [CW-1:0]     recheck;
  logic [HW-1:0]     syn;
  logic              odd;
  logic [DATA_W-1:0] flip;
  logic              hit_check;

  edac_encoder #(.DATA_W(DATA_W)) u_recalc (
    .secded(1'b1),
    .data  (data_in),
    .check (recheck)
  );

  assign syn       = recheck[HW-1:0] ^ check_in[HW-1:0];
  assign odd       = recheck[HW] ^ check_in[HW] ^ (^syn);
  assign hit_check = ($countones(syn) <= 1);

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_flip
      assign flip[g] = (int'(syn) == edac_pkg::data_pos(g));
    end
  endgenerate

  always_comb begin
    data_out  = data_in;
    corrected = 1'b0;
    uncorr    = 1'b0;
    if (!secded) begin
      uncorr = (^data_in) ^ check_in[0];
    end else if (odd) begin
      if (hit_check) begin
        corrected = 1'b1;
      end else if (|flip) begin
        corrected = 1'b1;
        data_out  = data_in ^ flip;
      end else begin
        uncorr = 1'b1;
      end
    end else if (syn != '0) begin
      uncorr = 1'b1;
    end
  end
endmodule

// File: rtl/edac_fail_log.sv
module edac_fail_log #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_corr,
  input  logic              ev_any,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              clr,
  output logic              ce_sticky,
  output logic [DATA_W-1:0] diag_data,
  output logic              fail_valid,
  output logic [ADDR_W-1:0] fail_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_sticky  <= 1'b0;
      diag_data  <= '0;
      fail_valid <= 1'b0;
      fail_addr  <= '0;
    end else begin
      if (ev_corr) begin
        diag_data <= ev_data;
        ce_sticky <= 1'b1;
      end else if (clr) begin
        ce_sticky <= 1'b0;
      end
      if (ev_any && (!fail_valid || clr)) begin
        fail_valid <= 1'b1;
        fail_addr  <= ev_addr;
      end else if (clr) begin
        fail_valid <= 1'b0;
      end
    end
  end

  // R7: a held failure address is not overwritten without a clear
  a_r7_first_kept: assert property (@(posedge clk) disable iff (rst)
    (fail_valid && !clr) |=> (fail_valid && $stable(fail_addr)));

  // R8: a clear with no new error drops the valid flag and sticky bit
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !ev_any && !ev_corr) |=> (!fail_valid && !ce_sticky));

  // R9: sticky bit holds until cleared
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (ce_sticky && !clr) |=> ce_sticky);

  // R6: diagnostic word only changes on a corrected read
  a_r6_diag_stable: assert property (@(posedge clk) disable iff (rst)
    !ev_corr |=> $stable(diag_data));
endmodule

// File: rtl/edac_guard.sv
module edac_guard #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  localparam int HW = edac_pkg::ham_bits(DATA_W),
  localparam int CW = HW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              secded_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CW-1:0]     wr_check,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CW-1:0]     rd_check,
  input  logic              fail_clr,
  output logic              rd_out_valid,
  output logic [DATA_W-1:0] rd_out_data,
  output logic              rd_out_corrected,
  output logic              rd_out_uncorr,
  output logic              ce_sticky,
  output logic [DATA_W-1:0] diag_data,
  output logic              fail_valid,
  output logic [ADDR_W-1:0] fail_addr
);
  logic [CW-1:0]     enc_check;
  logic [DATA_W-1:0] dec_data;
  logic              dec_corr;
  logic              dec_uncorr;

  edac_encoder #(.DATA_W(DATA_W)) u_enc (
    .secded(secded_en),
    .data  (wr_data),
    .check (enc_check)
  );

  edac_decoder #(.DATA_W(DATA_W)) u_dec (
    .secded   (secded_en),
    .data_in  (rd_data),
    .check_in (rd_check),
    .data_out (dec_data),
    .corrected(dec_corr),
    .uncorr   (dec_uncorr)
  );

  edac_fail_log #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_log (
    .clk       (clk),
    .rst       (rst),
    .ev_corr   (rd_valid && dec_corr),
    .ev_any    (rd_valid && (dec_corr || dec_uncorr)),
    .ev_addr   (rd_addr),
    .ev_data   (dec_data),
    .clr       (fail_clr),
    .ce_sticky (ce_sticky),
    .diag_data (diag_data),
    .fail_valid(fail_valid),
    .fail_addr (fail_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_check         <= '0;
      rd_out_valid     <= 1'b0;
      rd_out_data      <= '0;
      rd_out_corrected <= 1'b0;
      rd_out_uncorr    <= 1'b0;
    end else begin
      wr_check         <= enc_check;
      rd_out_valid     <= rd_valid;
      rd_out_data      <= rd_valid ? dec_data : rd_out_data;
      rd_out_corrected <= rd_valid && dec_corr;
      rd_out_uncorr    <= rd_valid && dec_uncorr;
    end
  end

  // R4: corrected and uncorrectable never reported together
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_out_corrected && rd_out_uncorr));

  // R10: flags only accompany a valid result
  a_r10_flag_valid: assert property (@(posedge clk) disable iff (rst)
    (rd_out_corrected || rd_out_uncorr) |-> rd_out_valid);

  // R5: parity mode passes data through and never corrects
  a_r5_parity_pass: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !secded_en) |=> (rd_out_data == $past(rd_data) && !rd_out_corrected));

  // R10: result valid one cycle after a read
  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_out_valid);
endmodule

// File: tb/tb_edac_guard.sv
module tb_edac_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic        secded_en;
  logic [15:0] wr_data;
  logic [5:0]  wr_check;
  logic        rd_valid;
  logic [19:0] rd_addr;
  logic [15:0] rd_data;
  logic [5:0]  rd_check;
  logic        fail_clr;
  logic        rd_out_valid;
  logic [15:0] rd_out_data;
  logic        rd_out_corrected;
  logic        rd_out_uncorr;
  logic        ce_sticky;
  logic [15:0] diag_data;
  logic        fail_valid;
  logic [19:0] fail_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edac_guard dut (
    .clk(clk), .rst(rst), .secded_en(secded_en),
    .wr_data(wr_data), .wr_check(wr_check),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_check(rd_check),
    .fail_clr(fail_clr),
    .rd_out_valid(rd_out_valid), .rd_out_data(rd_out_data),
    .rd_out_corrected(rd_out_corrected), .rd_out_uncorr(rd_out_uncorr),
    .ce_sticky(ce_sticky), .diag_data(diag_data),
    .fail_valid(fail_valid), .fail_addr(fail_addr)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // encode a word; result sampled at the negedge after the capturing edge
  task automatic encode(input logic [15:0] d, output logic [5:0] c);
    @(negedge clk);
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    c = wr_check;
  endtask

  // one read; outputs sampled one edge later
  task automatic do_read(input logic [19:0] a, input logic [15:0] d, input logic [5:0] c,
                         input logic clr);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_data = d; rd_check = c; fail_clr = clr;
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0; fail_clr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    fail_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fail_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "valid after reset", rd_out_valid, 0);
    chk("R10", "uncorr after reset", rd_out_uncorr, 0);
    chk("R10", "corr after reset", rd_out_corrected, 0);
    chk("R10", "sticky after reset", ce_sticky, 0);
    chk("R10", "fail_valid after reset", fail_valid, 0);
    chk("R10", "fail_addr after reset", fail_addr, 0);
    chk("R10", "diag after reset", diag_data, 0);
  endtask

  task automatic t_clean();
    logic [15:0] pats [5] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h1234, 16'h8001};
    logic [5:0] c;
    secded_en = 1'b1;
    foreach (pats[i]) begin
      encode(pats[i], c);
      do_read(20'h100 + 20'(i), pats[i], c, 1'b0);
      chk("R1", "clean data", rd_out_data, pats[i]);
      chk("R1", "clean corr flag", rd_out_corrected, 0);
      chk("R1", "clean uncorr flag", rd_out_uncorr, 0);
      chk("R10", "valid pulse", rd_out_valid, 1);
    end
    @(negedge clk);
    chk("R10", "valid drops", rd_out_valid, 0);
    chk("R1", "no fail logged", fail_valid, 0);
  endtask

  task automatic t_single_data();
    logic [15:0] d = 16'h5A3C;
    logic [5:0] c;
    secded_en = 1'b1;
    encode(d, c);
    for (int b = 0; b < 16; b++) begin
      do_read(20'h2000, d ^ (16'h1 << b), c, 1'b0);
      chk("R2", "repaired data", rd_out_data, d);
      chk("R2", "corr flag", rd_out_corrected, 1);
      chk("R2", "uncorr flag", rd_out_uncorr, 0);
    end
    chk("R6", "diag holds repaired word", diag_data, d);
    chk("R9", "sticky set", ce_sticky, 1);
    pulse_clr();
  endtask

  task automatic t_single_check();
    logic [15:0] d = 16'hC0DE;
    logic [5:0] c;
    secded_en = 1'b1;
    encode(d, c);
    for (int b = 0; b < 6; b++) begin
      do_read(20'h3000, d, c ^ (6'h1 << b), 1'b0);
      chk("R3", "data unchanged", rd_out_data, d);
      chk("R3", "corr flag", rd_out_corrected, 1);
      chk("R3", "uncorr flag", rd_out_uncorr, 0);
    end
    chk("R6", "diag after check-bit fix", diag_data, d);
    pulse_clr();
  endtask

  task automatic t_double();
    logic [15:0] d = 16'h0F0F;
    logic [15:0] dg;
    logic [5:0] c;
    secded_en = 1'b1;
    encode(d, c);
    dg = diag_data;
    do_read(20'h4000, d ^ 16'h0003, c, 1'b0);
    chk("R4", "two data bits uncorr", rd_out_uncorr, 1);
    chk("R4", "two data bits corr", rd_out_corrected, 0);
    do_read(20'h4001, d ^ 16'h8000, c ^ 6'h04, 1'b0);
    chk("R4", "data+check uncorr", rd_out_uncorr, 1);
    chk("R4", "data+check corr", rd_out_corrected, 0);
    do_read(20'h4002, d, c ^ 6'h21, 1'b0);
    chk("R4", "two check bits uncorr", rd_out_uncorr, 1);
    chk("R6", "diag untouched by uncorr", diag_data, dg);
    chk("R9", "sticky not set by uncorr", ce_sticky, 0);
    pulse_clr();
  endtask

  task automatic t_fail_log();
    logic [15:0] d = 16'h7777;
    logic [5:0] c;
    secded_en = 1'b1;
    encode(d, c);
    pulse_clr();
    chk("R8", "cleared valid", fail_valid, 0);
    do_read(20'hAAAAA, d ^ 16'h0010, c, 1'b0);
    chk("R7", "first addr", fail_addr, 20'hAAAAA);
    chk("R7", "valid set", fail_valid, 1);
    do_read(20'h55555, d ^ 16'h0300, c, 1'b0);
    chk("R7", "first kept", fail_addr, 20'hAAAAA);
    do_read(20'h12345, d, c, 1'b0);
    chk("R9", "sticky holds over clean read", ce_sticky, 1);
    pulse_clr();
    chk("R8", "clear drops valid", fail_valid, 0);
    chk("R8", "clear drops sticky", ce_sticky, 0);
    do_read(20'h0BEEF, d ^ 16'h0001, c, 1'b1);
    chk("R8", "same-cycle capture addr", fail_addr, 20'h0BEEF);
    chk("R8", "same-cycle capture valid", fail_valid, 1);
    chk("R8", "same-cycle sticky", ce_sticky, 1);
    do_read(20'h0CAFE, d ^ 16'h0006, c, 1'b1);
    chk("R8", "clear with new error recaptures", fail_addr, 20'h0CAFE);
    pulse_clr();
  endtask

  task automatic t_parity();
    logic [15:0] d = 16'hB371;
    logic [5:0] c;
    logic [5:0] exp;
    secded_en = 1'b0;
    encode(d, c);
    exp = {5'b0, ^d};
    chk("R5", "parity check field", c, exp);
    encode(16'h0001, c);
    chk("R5", "parity of one bit", c, 6'h01);
    do_read(20'h6000, d, exp ^ 6'h1E, 1'b0);
    chk("R5", "upper bits ignored uncorr", rd_out_uncorr, 0);
    chk("R5", "upper bits ignored data", rd_out_data, d);
    do_read(20'h6001, d ^ 16'h0100, exp, 1'b0);
    chk("R5", "mismatch uncorr", rd_out_uncorr, 1);
    chk("R5", "mismatch no corr", rd_out_corrected, 0);
    chk("R5", "data passed raw", rd_out_data, d ^ 16'h0100);
    chk("R5", "sticky not set", ce_sticky, 0);
    chk("R7", "parity error logged", fail_addr, 20'h6001);
    pulse_clr();
  endtask

  initial begin
    rst = 1'b1; secded_en = 1'b1; wr_data = '0; rd_valid = 1'b0;
    rd_addr = '0; rd_data = '0; rd_check = '0; fail_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clean();
    t_single_data();
    t_single_check();
    t_double();
    t_fail_log();
    t_parity();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule